// File: doc/BRIEF.md
# Ordered Three-Address Fetch Break Detector

This unit watches the instruction fetch stream of a small processor and requests a break only when three programmed fetch addresses appear in a fixed order. The first and second addresses each need to be seen once. The third address must then be fetched a programmable number of times. Only fetch cycles marked valid, while the unit is enabled, are compared against the programmed addresses.

The unit moves through three stages. Each stage compares the fetch address against only its own programmed address. A match on an address that belongs to a later stage is ignored until the earlier stages are done. When the last required hit on the third address arrives, the unit pulses its break request for one cycle and returns to the first stage. A clear input restarts the sequence at any time. The current stage and the count of third-address hits so far are brought out for observation. The break request is meant to be ORed with the requests of other, independent break sources outside the unit.

Top module: `pcseq_break`

## Requirements
- R1: After reset, `stage_o` is 0, `hits_o` is 0 and `brk_req` is low.
- R2: Stage encoding is 0 = waiting for first address, 1 = waiting for second, 2 = counting third. In stage 0, only a qualified fetch of `addr_first` moves the stage to 1. Fetches of any other address, including `addr_second` and `addr_third`, leave the stage at 0.
- R3: In stage 1, only a qualified fetch of `addr_second` moves the stage to 2 with `hits_o` set to 0. Any other address leaves the stage at 1.
- R4: In stage 2, each qualified fetch of `addr_third` either adds one to `hits_o` or, if it is the `pass_cnt`-th such hit, fires. A fire drives `brk_req` high in the cycle after that fetch.
- R5: A `pass_cnt` of 0 behaves the same as 1: the first hit on the third address fires.
- R6: `brk_req` is high for exactly one cycle per fire. In that same cycle, `stage_o` is 0 and `hits_o` is 0.
- R7: When `clr` is high, the next cycle shows `stage_o` 0, `hits_o` 0 and `brk_req` low. This holds even if a matching fetch is present in the same cycle.
- R8: A fetch is qualified only when `fetch_vld` and `en` are both high. In any other cycle, stage and hit count hold and no break is raised.
- R9: A single fetch advances the sequence by at most one stage. If all three addresses are equal and `pass_cnt` is 1, three qualified fetches are needed to fire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables comparison |
| clr | input | 1 | Restarts the sequence |
| fetch_vld | input | 1 | Fetch address is valid this cycle |
| fetch_pc | input | ADDR_W (16) | Fetch program counter |
| addr_first | input | ADDR_W (16) | First address of the sequence |
| addr_second | input | ADDR_W (16) | Second address of the sequence |
| addr_third | input | ADDR_W (16) | Third, counted address |
| pass_cnt | input | CNT_W (8) | Required hits on the third address (0 treated as 1) |
| brk_req | output | 1 | One-cycle break request |
| stage_o | output | 2 | Current stage |
| hits_o | output | CNT_W (8) | Third-address hits counted so far |

## Verification
The assertions check the following on every cycle:
- the break request lasts exactly one cycle;
- a break is only ever preceded by a qualified third-address fetch in stage 2;
- clear restarts the sequence;
- the state holds in unqualified cycles;
- stage 0 never jumps straight to stage 2.

Only the bench scenarios can show that the sequence actually fires at the right hit count. The same goes for the zero-count substitution, ignoring out-of-order addresses, and the equal-address case. These are checked against a behavioural model, together with a directed count of break pulses.

// File: rtl/pcseq_break_pkg.sv
package pcseq_break_pkg;
    typedef enum logic [1:0] {
        STG_FIRST  = 2'd0,
        STG_SECOND = 2'd1,
        STG_THIRD  = 2'd2
    } stage_e;

    localparam int unsigned NUM_STAGES = 3;
endpackage

// File: rtl/pcseq_addr_cmp.sv
module pcseq_addr_cmp #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned N      = 3
) (
    input  logic [ADDR_W-1:0]   pc,
    input  logic [N*ADDR_W-1:0] targets,
    output logic [N-1:0]        hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = (pc == targets[g*ADDR_W +: ADDR_W]);
    end
endmodule

// File: rtl/pcseq_pass_limit.sv
module pcseq_pass_limit #(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] pass_cnt,
    input  logic [CNT_W-1:0] hits,
    output logic             last_hit
);
    logic [CNT_W-1:0] eff_pass;
    logic [CNT_W:0]   next_hits;

    always_comb begin
        eff_pass  = (pass_cnt == '0) ? CNT_W'(1) : pass_cnt;
        next_hits = {1'b0, hits} + (CNT_W+1)'(1);
        last_hit  = (next_hits >= {1'b0, eff_pass});
    end
endmodule

// File: rtl/pcseq_break.sv
module pcseq_break
    import pcseq_break_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [ADDR_W-1:0] addr_first,
    input  logic [ADDR_W-1:0] addr_second,
    input  logic [ADDR_W-1:0] addr_third,
    input  logic [CNT_W-1:0]  pass_cnt,
    output logic              brk_req,
    output logic [1:0]        stage_o,
    output logic [CNT_W-1:0]  hits_o
);
    localparam int unsigned N = NUM_STAGES;

    typedef struct packed {
        stage_e           stage;
        logic [CNT_W-1:0] hits;
        logic             brk;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [N-1:0] addr_hit;
    logic         last_hit;
    logic         qual;

    pcseq_addr_cmp #(.ADDR_W(ADDR_W), .N(N)) u_cmp (
        .pc      (fetch_pc),
        .targets ({addr_third, addr_second, addr_first}),
        .hit     (addr_hit)
    );

    pcseq_pass_limit #(.CNT_W(CNT_W)) u_lim (
        .pass_cnt (pass_cnt),
        .hits     (st_q.hits),
        .last_hit (last_hit)
    );

    assign qual = fetch_vld && en;

    always_comb begin
        st_d     = st_q;
        st_d.brk = 1'b0;
        if (clr) begin
            st_d.stage = STG_FIRST;
            st_d.hits  = '0;
        end else if (qual) begin
            unique case (st_q.stage)
                STG_FIRST: begin
                    if (addr_hit[0]) st_d.stage = STG_SECOND;
                end
                STG_SECOND: begin
                    if (addr_hit[1]) begin
                        st_d.stage = STG_THIRD;
                        st_d.hits  = '0;
                    end
                end
                STG_THIRD: begin
                    if (addr_hit[2]) begin
                        if (last_hit) begin
                            st_d.brk   = 1'b1;
                            st_d.stage = STG_FIRST;
                            st_d.hits  = '0;
                        end else begin
                            st_d.hits = st_q.hits + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    st_d.stage = STG_FIRST;
                    st_d.hits  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stage <= STG_FIRST;
            st_q.hits  <= '0;
            st_q.brk   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign brk_req = st_q.brk;
    assign stage_o = st_q.stage;
    assign hits_o  = st_q.hits;
endmodule

// File: rtl/pcseq_break_chk.sv
module pcseq_break_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              clr,
    input logic              fetch_vld,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [ADDR_W-1:0] addr_third,
    input logic              brk_req,
    input logic [1:0]        stage_o,
    input logic [CNT_W-1:0]  hits_o
);
    assert_pulse_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !brk_req);

    assert_fire_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (stage_o == 2'd0 && hits_o == '0));

    assert_fire_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_req) |-> $past(fetch_vld && en && !clr && stage_o == 2'd2
                                 && fetch_pc == addr_third));

    assert_clear_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (stage_o == 2'd0 && hits_o == '0 && !brk_req));

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(fetch_vld && en)) |=> ($stable(stage_o) && $stable(hits_o) && !brk_req));

    assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_o == 2'd0) |=> (stage_o != 2'd2));

    assert_legal_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stage_o != 2'd3);
endmodule

bind pcseq_break pcseq_break_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .clr        (clr),
    .fetch_vld  (fetch_vld),
    .fetch_pc   (fetch_pc),
    .addr_third (addr_third),
    .brk_req    (brk_req),
    .stage_o    (stage_o),
    .hits_o     (hits_o)
);

// File: tb/pcseq_break_test.sv
module pcseq_break_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b1;
    logic              clr = 1'b0;
    logic              fetch_vld = 1'b0;
    logic [ADDR_W-1:0] fetch_pc = '0;
    logic [ADDR_W-1:0] addr_first = 16'h0100;
    logic [ADDR_W-1:0] addr_second = 16'h0200;
    logic [ADDR_W-1:0] addr_third = 16'h0300;
    logic [CNT_W-1:0]  pass_cnt = 8'd1;
    logic              brk_req;
    logic [1:0]        stage_o;
    logic [CNT_W-1:0]  hits_o;

    int n_cmp = 0;
    int n_bad = 0;
    int n_pulses = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_stage = 0;
    int m_hits = 0;
    bit m_brk = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcseq_break uut (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(clr),
        .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
        .addr_first(addr_first), .addr_second(addr_second), .addr_third(addr_third),
        .pass_cnt(pass_cnt), .brk_req(brk_req), .stage_o(stage_o), .hits_o(hits_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stage = 0; m_hits = 0; m_brk = 0;
        end else begin
            int need;
            need  = (pass_cnt == 0) ? 1 : int'(pass_cnt);
            m_brk = 0;
            if (clr) begin
                m_stage = 0; m_hits = 0;
            end else if (fetch_vld && en) begin
                if (m_stage == 0 && fetch_pc == addr_first) m_stage = 1;
                else if (m_stage == 1 && fetch_pc == addr_second) begin
                    m_stage = 2; m_hits = 0;
                end else if (m_stage == 2 && fetch_pc == addr_third) begin
                    if (m_hits + 1 >= need) begin
                        m_brk = 1; m_stage = 0; m_hits = 0;
                    end else m_hits++;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_bad++;
            $display("FAIL watchdog: run exceeded cycle limit");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic compare();
        n_cmp++;
        if (brk_req) n_pulses++;
        if (brk_req !== m_brk || int'(stage_o) != m_stage || int'(hits_o) != m_hits) begin
            n_bad++;
            $display("FAIL %s: brk/stage/hits actual %0b/%0d/%0d expected %0b/%0d/%0d",
                     cur_req, brk_req, stage_o, hits_o, m_brk, m_stage, m_hits);
        end
    endtask

    task automatic check_val(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [ADDR_W-1:0] pc, input logic fv);
        fetch_pc  = pc;
        fetch_vld = fv;
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(16'hFFFF, 1'b0);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare();
        check_val("R1", int'(stage_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare();

        // R2: out-of-order addresses ignored in stage 0
        cur_req = "R2";
        cyc(addr_third, 1); cyc(addr_second, 1); cyc(16'h0555, 1);
        check_val("R2", int'(stage_o), 0);
        cyc(addr_first, 1);
        check_val("R2", int'(stage_o), 1);

        // R3
        cur_req = "R3";
        cyc(addr_first, 1); cyc(addr_third, 1);
        check_val("R3", int'(stage_o), 1);
        cyc(addr_second, 1);
        check_val("R3", int'(stage_o), 2);

        // R4 with pass count 3
        cur_req = "R4";
        pass_cnt = 8'd3;
        base = n_pulses;
        cyc(addr_third, 1); cyc(addr_first, 1); cyc(addr_third, 1);
        check_val("R4", int'(hits_o), 2);
        cyc(addr_third, 1);
        check_val("R4", int'(brk_req), 1);
        cur_req = "R6";
        cyc(16'h0000, 0);
        check_val("R6", int'(brk_req), 0);
        check_val("R4", n_pulses - base, 1);

        // R5: pass count 0 acts as 1
        cur_req = "R5";
        pass_cnt = 8'd0;
        cyc(addr_first, 1); cyc(addr_second, 1); cyc(addr_third, 1);
        check_val("R5", int'(brk_req), 1);
        idle(2);

        // R8: unqualified fetches
        cur_req = "R8";
        pass_cnt = 8'd1;
        cyc(addr_first, 0);
        check_val("R8", int'(stage_o), 0);
        en = 1'b0;
        cyc(addr_first, 1);
        check_val("R8", int'(stage_o), 0);
        en = 1'b1;
        cyc(addr_first, 1); cyc(addr_second, 1);
        en = 1'b0;
        cyc(addr_third, 1);
        check_val("R8", int'(brk_req), 0);
        en = 1'b1;

        // R7: clear beats a matching fetch
        cur_req = "R7";
        clr = 1'b1;
        cyc(addr_third, 1);
        clr = 1'b0;
        check_val("R7", int'(stage_o), 0);
        check_val("R7", int'(brk_req), 0);

        // R9: equal addresses
        cur_req = "R9";
        addr_first = 16'h0ABC; addr_second = 16'h0ABC; addr_third = 16'h0ABC;
        cyc(16'h0ABC, 1); cyc(16'h0ABC, 1);
        check_val("R9", int'(brk_req), 0);
        cyc(16'h0ABC, 1);
        check_val("R9", int'(brk_req), 1);
        idle(1);

        // random stream against the model
        cur_req = "R4";
        addr_first = 16'h0010; addr_second = 16'h0020; addr_third = 16'h0030;
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 4));
            pass_cnt = 8'($urandom_range(0, 3));
            clr = ($urandom_range(0, 40) == 0);
            en  = ($urandom_range(0, 9) != 0);
            case (r)
                0: cyc(addr_first, 1'($urandom_range(0, 1) | 1));
                1: cyc(addr_second, 1);
                2: cyc(addr_third, 1);
                3: cyc(addr_third, 1'($urandom_range(0, 1)));
                default: cyc(16'($urandom), 1'($urandom_range(0, 1)));
            endcase
        end
        clr = 1'b0; en = 1'b1;
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule